// File: doc/BRIEF.md
# Timebase Prescaler with Oscillator Stabilization Wait

This block is a free-running binary prescaler clocked by the main oscillator. Three services come from its single count: an interval event that raises a software-visible flag and an interrupt request, a set of divided clock taps that other peripherals (for example a pulse generator) use as their timing reference, and an oscillation-stabilization wait that tells the clock controller when the main clock may be trusted after power-on or after a clock-stopping mode ends.

Three mode inputs report that the oscillator is about to stop: main stop, PLL stop and sub-clock operation. While any of them is high the count is forced to zero and held there, the stabilization-done output drops, and a clear pulse is sent to the companion watchdog counter so both counters restart in step. When all three fall, the count resumes from zero and stabilization-done rises once the selected wait length has elapsed. Software owns one small control register with an interval select, an interrupt enable, the interval flag and a self-clearing counter-clear bit.

Top module: `tbase_timer`

## Requirements
- R1: While any of `main_stop`, `pll_stop` or `sub_mode` is high, the counter is zero from the next edge on, all taps read 0 and `clk_ok` is 0.
- R2: After reset is released, `clk_ok` stays 0 until the counter has advanced the selected number of cycles, then goes to 1 on that edge and stays 1 until a stop mode is entered.
- R3: `stab_sel` 0, 1, 2, 3 selects a stabilization wait of 2^STB_E0, 2^STB_E1, 2^STB_E2, 2^STB_E3 cycles, counted from the first edge after the stop inputs all fall.
- R4: `wdt_clr` is high in exactly the cycles in which the counter is being cleared: any stop input high, or a write with `wr_data[0]` = 1.
- R5: A counter clear restarts interval timing: with no further clear, the next interval flag sets exactly 2^E cycles after the clear edge, E being the selected interval exponent.
- R6: Tap output `taps[i]` is counter bit TAP_LSB+i with no filtering, so after a clear its phase restarts from zero.
- R7: The interval flag is cleared by a write with `wr_data[1]` = 0; a write with `wr_data[1]` = 1 leaves it unchanged; `irq` equals the flag AND the enable bit `wr_data[2]`/`rd_data[2]`.
- R8: `rd_data[4:3]` (the interval select) 0, 1, 2, 3 picks an interval of 2^IVL_E0, 2^IVL_E1, 2^IVL_E2, 2^IVL_E3 cycles; the flag sets each time the counter reaches a multiple of the selected interval.
- R9: Every write loads the enable and interval select from `wr_data[2]` and `wr_data[4:3]`; the clear bit `rd_data[0]` always reads 0, and a clear does not change the flag.
- R10: When an interval event and a write of 0 to the flag fall on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 5 | Write data: [0] clear, [1] flag, [2] enable, [4:3] interval select |
| rd_data | output | 5 | Control register read-back, same layout, bit 0 reads 0 |
| irq | output | 1 | Interval interrupt request |
| main_stop | input | 1 | Main stop mode: oscillator halted |
| pll_stop | input | 1 | PLL stop mode: oscillator halted |
| sub_mode | input | 1 | Sub-clock mode: main oscillator halted |
| stab_sel | input | 2 | Stabilization wait length select |
| clk_ok | output | 1 | Stabilization wait complete |
| wdt_clr | output | 1 | Clear pulse to the watchdog counter |
| taps | output | TAP_N | Divided clock taps from the counter |

## Verification
Checked on every cycle by properties: the counter is zero and stabilization is dropped after any stop cycle, the counter steps by one whenever no clear is pending, a clear pulse always leaves the counter at zero, the flag only rises after an interval event, a matching event always leaves the flag set even against a write of 0, and stabilization-done rises only when the selected length is reached. Only the bench scenarios show the absolute lengths of each stabilization and interval choice, the restart of interval timing after a mid-period clear, the read-back of the register fields, and the agreement of taps, flag and interrupt with a cycle-level reference under random writes and mode changes.

// File: rtl/tbase_pkg.sv
// Package: shared control-register layout and exponent selection for the
// timebase prescaler. Assumes every exponent is below the counter width.
package tbase_pkg;

    // Control register layout as written and read by software
    typedef struct packed {
        logic [1:0] isel;   // interval select
        logic       ie;     // interrupt enable
        logic       flag;   // interval flag (write 0 clears)
        logic       clr;    // counter clear (write 1, reads 0)
    } tb_ctrl_t;

    // Pick one of four exponents by a 2-bit select
    function automatic int pick4(input logic [1:0] s, input int e0, input int e1,
                                 input int e2, input int e3);
        case (s)
            2'd0:    return e0;
            2'd1:    return e1;
            2'd2:    return e2;
            default: return e3;
        endcase
    endfunction

endpackage

// File: rtl/tbase_count.sv
// Module: the prescaler counter. Counts up every cycle, is forced to zero
// while a clock-stopping mode is active or software requests a clear, and
// reports that clear to the watchdog in the same cycle.
module tbase_count #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop,
    input  logic             sw_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             wdt_clr
);

    // Counting is allowed only when no clear source is active
    assign run     = !stop && !sw_clr;
    assign wdt_clr = stop || sw_clr;

    // Counter: clear-and-hold, else increment with wrap
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (!run) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end

    // R1
    stop_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (cnt == '0));
    // R4
    wdt_clears_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |=> (cnt == '0));
    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/tbase_flag.sv
// Module: control register and interval flag. Detects the counter reaching a
// multiple of the selected interval, sets the flag (set beats a software
// clear on the same edge) and forms the interrupt request.
module tbase_flag #(
    parameter int CNT_W  = 20,
    parameter int IVL_E0 = 12,
    parameter int IVL_E1 = 14,
    parameter int IVL_E2 = 16,
    parameter int IVL_E3 = 19
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  tbase_pkg::tb_ctrl_t wr_ctrl,
    input  logic [CNT_W-1:0]    cnt,
    input  logic                run,
    output logic                flag,
    output logic                ie,
    output logic [1:0]          isel,
    output logic                irq
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] imask;
    logic             ev;

    // Mask of the low bits that roll over together at the interval boundary
    always_comb begin
        imask = (ONE << tbase_pkg::pick4(isel, IVL_E0, IVL_E1, IVL_E2, IVL_E3)) - ONE;
        ev    = run && ((cnt & imask) == imask);
    end

    // Enable and select load on any write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie   <= 1'b0;
            isel <= 2'd0;
        end else if (wr_en) begin
            ie   <= wr_ctrl.ie;
            isel <= wr_ctrl.isel;
        end
    end

    // Flag: hardware set wins over a software write of 0
    always_ff @(posedge clk) begin
        if (!rst_n)                      flag <= 1'b0;
        else if (ev)                     flag <= 1'b1;
        else if (wr_en && !wr_ctrl.flag) flag <= 1'b0;
    end

    assign irq = flag && ie;

    // R10
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> flag);
    // R7
    write_zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ctrl.flag && !ev) |=> !flag);
    // R8
    flag_rise_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(ev));

endmodule

// File: rtl/tbase_stab.sv
// Module: oscillation-stabilization tracker. The done bit drops whenever the
// oscillator is stopped and rises the first time the counter, restarted from
// zero, reaches the selected wait length.
module tbase_stab #(
    parameter int CNT_W  = 20,
    parameter int STB_E0 = 10,
    parameter int STB_E1 = 13,
    parameter int STB_E2 = 15,
    parameter int STB_E3 = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop,
    input  logic             run,
    input  logic [1:0]       stab_sel,
    input  logic [CNT_W-1:0] cnt,
    output logic             done
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] smask;
    logic             reach;

    // Wait length reached on the edge that takes the low bits past all-ones
    always_comb begin
        smask = (ONE << tbase_pkg::pick4(stab_sel, STB_E0, STB_E1, STB_E2, STB_E3)) - ONE;
        reach = run && ((cnt & smask) == smask);
    end

    // Done: cleared by stop modes, set once the wait elapses
    always_ff @(posedge clk) begin
        if (!rst_n)     done <= 1'b0;
        else if (stop)  done <= 1'b0;
        else if (reach) done <= 1'b1;
    end

    // R1
    stop_drops_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !done);
    // R3
    done_rise_on_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(reach));

endmodule

// File: rtl/tbase_timer.sv
// Module: timebase prescaler top. Joins the counter, the control/flag
// register and the stabilization tracker, and brings out divided taps.
// Assumes all exponents and TAP_LSB+TAP_N are within CNT_W.
module tbase_timer #(
    parameter int CNT_W   = 20,
    parameter int IVL_E0  = 12,
    parameter int IVL_E1  = 14,
    parameter int IVL_E2  = 16,
    parameter int IVL_E3  = 19,
    parameter int STB_E0  = 10,
    parameter int STB_E1  = 13,
    parameter int STB_E2  = 15,
    parameter int STB_E3  = 17,
    parameter int TAP_LSB = 5,
    parameter int TAP_N   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [4:0]       wr_data,
    output logic [4:0]       rd_data,
    output logic             irq,
    input  logic             main_stop,
    input  logic             pll_stop,
    input  logic             sub_mode,
    input  logic [1:0]       stab_sel,
    output logic             clk_ok,
    output logic             wdt_clr,
    output logic [TAP_N-1:0] taps
);

    import tbase_pkg::*;

    tb_ctrl_t         wr_ctrl;
    tb_ctrl_t         rd_ctrl;
    logic             stop;
    logic             sw_clr;
    logic             run;
    logic [CNT_W-1:0] cnt;
    logic             flag;
    logic             ie;
    logic [1:0]       isel;

    // Decode stop modes and the software clear request
    assign wr_ctrl = tb_ctrl_t'(wr_data);
    assign stop    = main_stop || pll_stop || sub_mode;
    assign sw_clr  = wr_en && wr_ctrl.clr;

    tbase_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .stop(stop), .sw_clr(sw_clr),
        .cnt(cnt), .run(run), .wdt_clr(wdt_clr)
    );

    tbase_flag #(.CNT_W(CNT_W), .IVL_E0(IVL_E0), .IVL_E1(IVL_E1),
                 .IVL_E2(IVL_E2), .IVL_E3(IVL_E3)) u_flag (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctrl(wr_ctrl),
        .cnt(cnt), .run(run), .flag(flag), .ie(ie), .isel(isel), .irq(irq)
    );

    tbase_stab #(.CNT_W(CNT_W), .STB_E0(STB_E0), .STB_E1(STB_E1),
                 .STB_E2(STB_E2), .STB_E3(STB_E3)) u_stab (
        .clk(clk), .rst_n(rst_n), .stop(stop), .run(run),
        .stab_sel(stab_sel), .cnt(cnt), .done(clk_ok)
    );

    // Read-back: clear bit always reads 0
    always_comb begin
        rd_ctrl      = '0;
        rd_ctrl.isel = isel;
        rd_ctrl.ie   = ie;
        rd_ctrl.flag = flag;
        rd_data      = rd_ctrl;
    end

    // Divided taps are raw counter bits
    for (genvar i = 0; i < TAP_N; i++) begin : g_tap
        assign taps[i] = cnt[TAP_LSB + i];
    end

    // R9
    clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[0] == 1'b0);

endmodule

// File: tb/tbase_timer_test.sv
`timescale 1ns/100ps
module tbase_timer_test;

    localparam int CW = 8;
    localparam int I0 = 3, I1 = 4, I2 = 5, I3 = 6;
    localparam int S0 = 2, S1 = 3, S2 = 4, S3 = 5;
    localparam int TL = 1, TN = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_data = '0;
    logic [4:0]    rd_data;
    logic          irq;
    logic          main_stop = 1'b0, pll_stop = 1'b0, sub_mode = 1'b0;
    logic [1:0]    stab_sel = 2'd0;
    logic          clk_ok;
    logic          wdt_clr;
    logic [TN-1:0] taps;

    tbase_timer #(.CNT_W(CW), .IVL_E0(I0), .IVL_E1(I1), .IVL_E2(I2), .IVL_E3(I3),
                  .STB_E0(S0), .STB_E1(S1), .STB_E2(S2), .STB_E3(S3),
                  .TAP_LSB(TL), .TAP_N(TN)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .irq(irq), .main_stop(main_stop), .pll_stop(pll_stop), .sub_mode(sub_mode),
        .stab_sel(stab_sel), .clk_ok(clk_ok), .wdt_clr(wdt_clr), .taps(taps)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // Reference state built from the requirements
    logic [CW-1:0] m_cnt;
    logic          m_flag, m_ie, m_done;
    logic [1:0]    m_isel;

    function automatic int iexp(input logic [1:0] s);
        return (s == 0) ? I0 : (s == 1) ? I1 : (s == 2) ? I2 : I3;
    endfunction
    function automatic int sexp(input logic [1:0] s);
        return (s == 0) ? S0 : (s == 1) ? S1 : (s == 2) ? S2 : S3;
    endfunction
    function automatic logic at_edge(input logic [CW-1:0] c, input int e);
        logic [CW-1:0] m;
        m = (CW'(1) << e) - CW'(1);
        return (c & m) == m;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Advance the reference by one edge using the inputs now applied
    task automatic model_edge();
        logic stp, sclr, run, ev, rch;
        stp  = main_stop | pll_stop | sub_mode;
        sclr = wr_en & wr_data[0];
        run  = !stp && !sclr;
        ev   = run && at_edge(m_cnt, iexp(m_isel));
        rch  = run && at_edge(m_cnt, sexp(stab_sel));
        if (ev) m_flag = 1'b1;
        else if (wr_en && !wr_data[1]) m_flag = 1'b0;
        if (wr_en) begin
            m_ie   = wr_data[2];
            m_isel = wr_data[4:3];
        end
        if (stp) m_done = 1'b0;
        else if (rch) m_done = 1'b1;
        m_cnt = run ? m_cnt + 1'b1 : '0;
    endtask

    task automatic cmp_all();
        chk("R6 taps", 8'(taps), 8'(m_cnt[TL +: TN]));
        chk("R8 flag", 8'(rd_data[1]), 8'(m_flag));
        chk("R7 irq", 8'(irq), 8'(m_flag & m_ie));
        chk("R9 readback", 8'({rd_data[4:2], rd_data[0]}), 8'({m_isel, m_ie, 1'b0}));
        chk("R2 clk_ok", 8'(clk_ok), 8'(m_done));
    endtask

    // One cycle: drive at negedge, check wdt_clr, clock, check registered outputs
    task automatic step(input logic we, input logic [4:0] wd, input logic [2:0] md,
                        input logic [1:0] ss);
        wr_en = we; wr_data = wd;
        {sub_mode, pll_stop, main_stop} = md;
        stab_sel = ss;
        #1;
        chk("R4 wdt_clr", 8'(wdt_clr), 8'((|md) | (we & wd[0])));
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cmp_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 5'd0, 3'd0, stab_sel);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int k;
        void'($urandom(32'd5150));
        m_cnt = '0; m_flag = 0; m_ie = 0; m_done = 0; m_isel = 0;
        repeat (3) @(negedge clk);
        cmp_all();                          // reset state
        chk("R9 reset rd_data", 8'(rd_data), 8'd0);
        rst_n = 1'b1;

        // R2: power-on wait with select 0
        k = 0;
        for (int i = 1; i <= 200; i++) begin
            step(1'b0, 5'd0, 3'd0, 2'd0);
            if (clk_ok) begin k = i; break; end
        end
        chk("R2 power-on wait", 8'(k), 8'(1 << S0));

        // R3: each wait length after each stop mode
        for (int s = 0; s < 4; s++) begin
            step(1'b0, 5'd0, 3'(1 << (s % 3)), 2'(s));
            k = 0;
            for (int i = 1; i <= 200; i++) begin
                step(1'b0, 5'd0, 3'd0, 2'(s));
                if (clk_ok) begin k = i; break; end
            end
            chk("R3 stab length", 8'(k), 8'(1 << sexp(2'(s))));
        end

        // R1: each stop input holds the counter and drops clk_ok
        for (int b = 0; b < 3; b++) begin
            idle(5);
            for (int i = 0; i < 4; i++) begin
                step(1'b0, 5'd0, 3'(1 << b), 2'd0);
                chk("R1 taps held", 8'(taps), 8'd0);
                chk("R1 clk_ok low", 8'(clk_ok), 8'd0);
            end
        end
        idle(8);

        // R5: clear mid-interval restarts interval timing (isel 0, ie 1)
        step(1'b1, 5'b00101, 3'd0, 2'd0);
        idle(5);
        step(1'b1, 5'b00101, 3'd0, 2'd0);
        k = 0;
        for (int i = 1; i <= 100; i++) begin
            step(1'b0, 5'd0, 3'd0, 2'd0);
            if (irq) begin k = i; break; end
        end
        chk("R5 interval after clear", 8'(k), 8'(1 << I0));

        // R10: set and software clear on the same edge
        step(1'b1, 5'b00101, 3'd0, 2'd0);
        idle(7);
        step(1'b1, 5'b00100, 3'd0, 2'd0);
        chk("R10 set wins", 8'(rd_data[1]), 8'd1);

        // R9: clear bit with flag kept reads back 0 and keeps the flag
        step(1'b1, 5'b00111, 3'd0, 2'd0);
        chk("R9 clear keeps fields", 8'(rd_data), 8'b00110);

        // R8: interval select 2
        step(1'b1, 5'b10101, 3'd0, 2'd0);
        k = 0;
        for (int i = 1; i <= 200; i++) begin
            step(1'b0, 5'd0, 3'd0, 2'd0);
            if (irq) begin k = i; break; end
        end
        chk("R8 interval select 2", 8'(k), 8'(1 << I2));

        // R7: enable off masks irq; write 1 keeps flag; write 0 clears it
        step(1'b1, 5'b10010, 3'd0, 2'd0);
        chk("R7 masked irq", 8'({irq, rd_data[1]}), 8'b01);
        step(1'b1, 5'b10000, 3'd0, 2'd0);
        chk("R7 write zero clears", 8'(rd_data[1]), 8'd0);

        // Random mix against the reference
        for (int i = 0; i < 15000; i++) begin
            logic       we;
            logic [4:0] wd;
            logic [2:0] md;
            logic [1:0] ss;
            we = ($urandom % 16) == 0;
            wd = 5'($urandom);
            wd[0] = ($urandom % 4) == 0;
            md = (($urandom % 120) == 0) ? 3'($urandom) : 3'd0;
            ss = (($urandom % 400) == 0) ? 2'($urandom) : stab_sel;
            step(we, wd, md, ss);
        end

        finish_run();
    end

endmodule